// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a processor's execute stage and a 32-bit data memory that is addressed in bytes and stores words big-endian: a word's address is that of its most significant byte, and word addresses step by 4. On the request side it takes a base register value, a signed 16-bit byte displacement, an access size (byte or word), a direction and the register value to store. It forms the effective address, rounds it down to a word boundary for the memory, moves store data onto the right byte lane and raises the matching byte write enables. Word accesses whose effective address is not a multiple of 4 are flagged and write nothing.

On the response side it takes the word the memory returned, together with the low two address bits and size of the load it belongs to. It extracts the addressed byte and sign-extends it, or passes a whole word through. A misaligned word load yields zero with an error flag.

Both paths are streams with one register stage each. A producer may hold `valid` high with stable payload until `ready` is seen. An output stage that holds data accepts a new beat only in a cycle where its consumer takes the old one, so `req_ready = !mem_valid || mem_ready`, and `rsp_ready` follows the same rule. While an output is valid and not ready, its payload does not change. An accepted beat appears at the output on the following clock edge.

Top module: `lsa_aligner`

## Requirements
- R1: The effective address is `req_base` plus the sign-extended `req_imm`, modulo 2^32. `mem_addr` equals that address with bits [1:0] cleared.
- R2: An aligned word store drives `mem_be = 4'b1111` and `mem_wdata = req_wdata`.
- R3: A byte store with effective-address bits [1:0] = k drives exactly one enable, `mem_be = 4'b1000 >> k`. Enable bit 3 covers data bits [31:24] and bit 0 covers bits [7:0]. `mem_wdata` carries `req_wdata[7:0]` in all four lanes.
- R4: A word access whose effective-address bits [1:0] are not zero sets `mem_err = 1` and drives `mem_be = 0`. Byte accesses never set `mem_err`.
- R5: A load request (`req_write = 0`) drives `mem_write = 0` and `mem_be = 0`.
- R6: A byte load response with `rsp_ofs = k` returns the byte at data bits [31-8k:24-8k] in `ld_data[7:0]`, with bits [31:8] copies of that byte's bit 7. It sets `ld_err = 0`.
- R7: A word load response with `rsp_ofs = 0` returns `rsp_rdata` unchanged with `ld_err = 0`.
- R8: A word load response with `rsp_ofs` not zero returns `ld_data = 0` with `ld_err = 1`.
- R9: Each path has a one-cycle latency. `req_ready = !mem_valid || mem_ready`. While `mem_valid && !mem_ready`, the outputs `mem_valid`, `mem_addr`, `mem_be`, `mem_wdata`, `mem_write` and `mem_err` hold their values. The load path obeys the same rules through `rsp_ready`, `ld_valid` and `ld_ready`.
- R10: During and straight after reset, `mem_valid = 0`, `ld_valid = 0` and `req_ready = 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed byte displacement |
| req_wdata | input | 32 | Register value to store |
| mem_valid | output | 1 | Memory command present |
| mem_ready | input | 1 | Memory takes the command |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_write | output | 1 | Command is a write |
| mem_be | output | 4 | Byte write enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_err | output | 1 | Misaligned word access |
| rsp_valid | input | 1 | Returned memory word present |
| rsp_ready | output | 1 | Response accepted this cycle |
| rsp_word | input | 1 | Load was a word access |
| rsp_ofs | input | 2 | Effective-address bits [1:0] of the load |
| rsp_rdata | input | 32 | Word returned by memory |
| ld_valid | output | 1 | Load result present |
| ld_ready | input | 1 | Consumer takes the load result |
| ld_data | output | 32 | Value for the destination register |
| ld_err | output | 1 | Misaligned word load |

## Verification
The bench targets lane order in both directions. A design that selects lanes little-endian would write offset 0 into bits [7:0] and would return the wrong byte on loads. It targets bytes with bit 7 set, which catch zero-extension in place of sign-extension. It targets negative displacements and a base near 2^32, which expose an adder that drops the sign of the displacement or fails to wrap. Misaligned word stores and loads show any design that still raises enables or leaks memory data. A stalled output while a second request waits shows any stage that overwrites or drops held data.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/lsa_pipe_stage.sv
module lsa_pipe_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign ready_o = !full_q || ready_i;
  assign valid_o = full_q;
  assign data_o  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (ready_o) begin
      full_q <= valid_i;
      if (valid_i) data_q <= data_i;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o))); // R9
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o) |-> ready_o); // R9
endmodule

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              is_word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              misalign_o
);
  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] eff;

  // displacement is signed; the sum wraps at the address width
  assign imm_ext    = {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign eff        = base_i + imm_ext;
  assign ofs_o      = eff[OFS_W-1:0];
  assign addr_o     = {eff[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign misalign_o = is_word_i && (ofs_o != '0);
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              is_word_i,
  input  logic              write_i,
  input  logic              misalign_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] data_o
);
  // big-endian: lane g (bits g*8 up) is addressed by offset LANES-1-g
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_OFS = OFS_W'(LANES - 1 - g);
    assign be_o[g] = write_i && !misalign_i && (is_word_i || (ofs_i == LANE_OFS));
    assign data_o[g*BYTE_W +: BYTE_W] = is_word_i ? wdata_i[g*BYTE_W +: BYTE_W]
                                                  : wdata_i[BYTE_W-1:0];
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              is_word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic [BYTE_W-1:0] lane [LANES];
  logic [OFS_W-1:0]  lane_idx;
  logic [BYTE_W-1:0] sel;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane[g] = rdata_i[g*BYTE_W +: BYTE_W];
  end

  assign lane_idx = OFS_W'(LANES - 1) - ofs_i;
  assign sel      = lane[lane_idx];
  assign err_o    = is_word_i && (ofs_i != '0);

  always_comb begin
    if (is_word_i) data_o = err_o ? '0 : rdata_i;
    else           data_o = {{(DATA_W-BYTE_W){sel[BYTE_W-1]}}, sel};
  end
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_err,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_word,
  input  logic [OFS_W-1:0]  rsp_ofs,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_err
);
  localparam int unsigned CMD_W = ADDR_W + 1 + LANES + DATA_W + 1;
  localparam int unsigned LD_W  = DATA_W + 1;

  acc_size_e req_sz, rsp_sz;
  assign req_sz = acc_size_e'(req_word);
  assign rsp_sz = acc_size_e'(rsp_word);

  // ---------------- store / command path ----------------
  logic [ADDR_W-1:0] ag_addr;
  logic [OFS_W-1:0]  ag_ofs;
  logic              ag_misalign;
  logic [LANES-1:0]  st_be;
  logic [DATA_W-1:0] st_data;
  logic [CMD_W-1:0]  cmd_d, cmd_q;

  lsa_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .LANES(LANES)) u_addr_gen (
    .base_i     (req_base),
    .imm_i      (req_imm),
    .is_word_i  (req_sz == ACC_WORD),
    .addr_o     (ag_addr),
    .ofs_o      (ag_ofs),
    .misalign_o (ag_misalign)
  );

  lsa_store_lane #(.DATA_W(DATA_W)) u_store_lane (
    .wdata_i    (req_wdata),
    .ofs_i      (ag_ofs),
    .is_word_i  (req_sz == ACC_WORD),
    .write_i    (req_write),
    .misalign_i (ag_misalign),
    .be_o       (st_be),
    .data_o     (st_data)
  );

  assign cmd_d = {ag_addr, req_write, st_be, st_data, ag_misalign};

  lsa_pipe_stage #(.W(CMD_W)) u_cmd_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (req_valid),
    .ready_o (req_ready),
    .data_i  (cmd_d),
    .valid_o (mem_valid),
    .ready_i (mem_ready),
    .data_o  (cmd_q)
  );

  assign {mem_addr, mem_write, mem_be, mem_wdata, mem_err} = cmd_q;

  // ---------------- load result path ----------------
  logic [DATA_W-1:0] lx_data;
  logic              lx_err;
  logic [LD_W-1:0]   ld_q;

  lsa_load_extract #(.DATA_W(DATA_W)) u_load_extract (
    .rdata_i   (rsp_rdata),
    .ofs_i     (rsp_ofs),
    .is_word_i (rsp_sz == ACC_WORD),
    .data_o    (lx_data),
    .err_o     (lx_err)
  );

  lsa_pipe_stage #(.W(LD_W)) u_ld_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (rsp_valid),
    .ready_o (rsp_ready),
    .data_i  ({lx_data, lx_err}),
    .valid_o (ld_valid),
    .ready_i (ld_ready),
    .data_o  (ld_q)
  );

  assign {ld_data, ld_err} = ld_q;

  // ---------------- assertions ----------------
  AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[OFS_W-1:0] == '0)); // R1
  AST_STORE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !mem_err) |-> ((mem_be == '1) || ($countones(mem_be) == 1))); // R3
  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_err) |-> (mem_be == '0)); // R4
  AST_LOAD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write) |-> (mem_be == '0)); // R5
  AST_BAD_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_err) |-> (ld_data == '0)); // R8
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_valid); // R9
endmodule

// File: tb/test_lsa_aligner.sv
`timescale 1ns/1ps
module test_lsa_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0, req_wdata = '0;
  logic [15:0] req_imm = '0;
  logic        mem_valid, mem_write, mem_err;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        rsp_valid = 1'b0, rsp_word = 1'b0;
  logic        rsp_ready;
  logic [1:0]  rsp_ofs = '0;
  logic [31:0] rsp_rdata = '0;
  logic        ld_valid, ld_err;
  logic        ld_ready = 1'b1;
  logic [31:0] ld_data;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsa_aligner i_lsa_aligner (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_word(req_word),
    .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_write(mem_write),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_err(mem_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_word(rsp_word), .rsp_ofs(rsp_ofs),
    .rsp_rdata(rsp_rdata), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .ld_err(ld_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_eff(input logic [31:0] b, input logic [15:0] i);
    return b + {{16{i[15]}}, i};
  endfunction

  function automatic logic [3:0] f_be(input bit w, input bit wd, input logic [1:0] k);
    if (!w) return 4'b0000;
    if (wd) return (k == 2'd0) ? 4'b1111 : 4'b0000;
    return 4'b1000 >> k;
  endfunction

  function automatic logic [31:0] f_ld(input bit wd, input logic [1:0] k, input logic [31:0] d);
    logic [7:0] b;
    if (wd) return (k == 2'd0) ? d : 32'h0;
    b = d[31 - 8*k -: 8];
    return {{24{b[7]}}, b};
  endfunction

  // drive one request at a negedge, check the command one edge later
  task automatic do_req(input bit w, input bit wd, input logic [31:0] b,
                        input logic [15:0] i, input logic [31:0] wv);
    logic [31:0] e;
    e = f_eff(b, i);
    req_valid = 1'b1; req_write = w; req_word = wd; req_base = b; req_imm = i; req_wdata = wv;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R9 mem_valid", {31'b0, mem_valid}, 32'd1);
    chk("R1 mem_addr", mem_addr, {e[31:2], 2'b00});
    chk("R5 mem_write", {31'b0, mem_write}, {31'b0, w});
    chk("R4 mem_err", {31'b0, mem_err}, {31'b0, (wd && e[1:0] != 2'd0)});
    chk(wd ? "R2 mem_be" : "R3 mem_be", {28'b0, mem_be}, {28'b0, f_be(w, wd, e[1:0])});
    if (w && !(wd && e[1:0] != 2'd0))
      chk(wd ? "R2 mem_wdata" : "R3 mem_wdata", mem_wdata, wd ? wv : {4{wv[7:0]}});
  endtask

  task automatic do_rsp(input bit wd, input logic [1:0] k, input logic [31:0] d);
    rsp_valid = 1'b1; rsp_word = wd; rsp_ofs = k; rsp_rdata = d;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
    chk("R9 ld_valid", {31'b0, ld_valid}, 32'd1);
    chk(wd ? ((k == 0) ? "R7 ld_data" : "R8 ld_data") : "R6 ld_data", ld_data, f_ld(wd, k, d));
    chk(wd ? "R8 ld_err" : "R6 ld_err", {31'b0, ld_err}, {31'b0, (wd && k != 2'd0)});
  endtask

  initial begin
    #500000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_addr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 mem_valid in reset", {31'b0, mem_valid}, 32'd0);
    chk("R10 ld_valid in reset", {31'b0, ld_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 mem_valid", {31'b0, mem_valid}, 32'd0);
    chk("R10 ld_valid", {31'b0, ld_valid}, 32'd0);
    chk("R10 req_ready", {31'b0, req_ready}, 32'd1);

    // directed corners
    for (int k = 0; k < 4; k++) do_req(1'b1, 1'b0, 32'h0000_1000, 16'(k), 32'hCAFE_BEA5);
    do_req(1'b1, 1'b1, 32'h0000_2000, 16'h0008, 32'h1234_5678);
    do_req(1'b1, 1'b1, 32'h0000_2000, 16'h0002, 32'h1234_5678);
    do_req(1'b0, 1'b1, 32'h0000_2001, 16'h0000, 32'h0);
    do_req(1'b0, 1'b0, 32'h0000_3000, 16'hFFF3, 32'h0);
    do_req(1'b1, 1'b0, 32'hFFFF_FFFE, 16'h0003, 32'h0000_0081);
    do_req(1'b1, 1'b1, 32'h0000_0004, 16'hFFF8, 32'hDEAD_0001);
    for (int k = 0; k < 4; k++) do_rsp(1'b0, 2'(k), 32'h80_7F_FF_01);
    do_rsp(1'b1, 2'd0, 32'h89AB_CDEF);
    do_rsp(1'b1, 2'd3, 32'h89AB_CDEF);

    // stall: held command must stay put while a second one waits (R9)
    mem_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1; req_base = 32'h100; req_imm = 16'h0;
    req_wdata = 32'h1111_1111;
    @(posedge clk); @(negedge clk);
    hold_addr = mem_addr;
    chk("R9 req_ready low when stalled", {31'b0, req_ready}, 32'd0);
    req_base = 32'h200; req_wdata = 32'h2222_2222;
    @(posedge clk); @(negedge clk);
    chk("R9 held addr", mem_addr, 32'h100);
    chk("R9 held data", mem_wdata, 32'h1111_1111);
    chk("R9 held valid", {31'b0, mem_valid}, 32'd1);
    mem_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next command", mem_addr, 32'h200);
    chk("R9 next data", mem_wdata, 32'h2222_2222);
    chk("R1 hold_addr", hold_addr, 32'h100);
    @(posedge clk); @(negedge clk);
    chk("R9 drained", {31'b0, mem_valid}, 32'd0);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [31:0] b, v;
      logic [15:0] i;
      bit w, wd;
      b = $urandom; i = 16'($urandom); v = $urandom;
      w = 1'($urandom); wd = 1'($urandom);
      if (($urandom % 3) != 0) begin b[1:0] = 2'b00; i[1:0] = 2'b00; end
      if (($urandom % 2) == 0) do_req(w, wd, b, i, v);
      else do_rsp(wd, 2'($urandom), v);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule